// File: doc/BRIEF.md
# NAND Command Sequence Decoder

This block is the device-side front end of a NAND flash interface. It watches the strobe, chip-enable and latch-select lines of an 8-bit multiplexed bus. Each bus cycle that is latched is classed as a command, an address or a data cycle. The block then follows the opcode sequences that make up the flash operations and raises a one-cycle strobe for each operation that completes legally. The strobes cover read, copy-back read, page program, copy-back program, block erase, cache program, cache read, status, ID and reset. A data-output strobe is also provided.

Two-cycle operations are checked for a matching setup and confirm opcode and for the number of address cycles between them. Two-plane chains are followed through their intermediate plane code. While the array side reports busy, commands other than the few allowed ones are rejected. Anything illegal gives a one-cycle error pulse, and the decoder goes back to idle. The bus lines are taken to be synchronous to `clk` already, and each latch strobe must stay low for at least one clock.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A bus cycle is taken only on a low-to-high transition of `we_n` while `ce_n` is low. Transitions with `ce_n` high have no effect. After reset all outputs are low.
- R2: A cycle with `cle` high is a command, a cycle with only `ale` high is an address, and any other cycle is data. Data cycles never change the address count.
- R3: Single-cycle commands give their strobe from idle. FFh gives reset (bit 9), 90h gives read ID (bit 8), 70h and F1h give status (bit 7), and 31h and 3Fh give cache read (bit 6).
- R4: Each of these pairs, with exactly COL_CYC+ROW_CYC address cycles in between, gives the strobe shown. 00h..30h gives read (bit 0). 00h..35h gives copy-back read (bit 1). 80h..10h gives program (bit 2). 85h..10h gives copy-back program (bit 3). 80h..15h gives cache program (bit 5).
- R5: 60h..D0h with ROW_CYC address cycles gives erase (bit 4). 05h..E0h with COL_CYC address cycles gives data output (bit 10).
- R6: A confirm or chain opcode (30h, 35h, 10h, 15h, 11h, D0h, E0h, 81h) that arrives without its setup gives a one-cycle `seq_err` and no strobe.
- R7: If the address count at a confirm differs from the expected count, the result is `seq_err` and no strobe.
- R8: While `busy` is high, only FFh, 70h and F1h are accepted. Any other command gives a one-cycle `busy_reject`, no strobe, and no change of sequence state.
- R9: A plane chain is setup..11h, then 80h, 81h or 85h with a new address phase, and then a final 10h or 15h. It gives a single strobe: program, cache program, or copy-back program when the chain opened with 85h.
- R10: After 11h, status commands are allowed and keep the chain. Any command other than FFh and the second-plane setups gives `seq_err`.
- R11: The two-plane read forms 60h,60h..30h/35h/33h give read, copy-back read or cache read. After one of these, 00h..05h..E0h is legal. Without one, 05h after 00h gives `seq_err`.
- R12: FFh aborts any sequence in progress and returns to idle with the reset strobe.
- R13: Inside a program setup, 85h first checks the address count, then restarts it with an expectation of COL_CYC cycles (random data input).
- R14: An unknown opcode in idle, or an unexpected command inside a setup, gives `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Latch strobe, cycle taken on its rising edge |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| io | input | 8 | Bus data |
| busy | input | 1 | Array side is busy |
| op_strobe | output | 11 | One-cycle operation strobes, bit map as in R3 to R5 |
| seq_err | output | 1 | One-cycle illegal-sequence pulse |
| busy_reject | output | 1 | One-cycle pulse for a command refused while busy |

## Verification
All 256 opcodes are swept once from idle and once under busy. The idle sweep separates single-cycle commands, setups and illegal codes. The busy sweep separates the allowed busy commands from the rejected ones. Address counts from zero to saturation are tried around a read pair, which shows that only the exact count completes. Directed chains cover plane sequences, status inside a chain, two-plane read followed by data output, random data input, chip-enable gating and abort by reset. Each of these separates a legal continuation from an error.

// File: rtl/nand_dec_pkg.sv
// Shared opcodes, cycle kinds, strobe indices and states of the NAND command decoder.
package nand_dec_pkg;
    typedef enum logic [1:0] {CYC_DATA, CYC_ADDR, CYC_CMD} cyc_kind_t;

    typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_PG, ST_ER, ST_DO, ST_PLANE} dec_state_t;

    localparam int OP_N          = 11;
    localparam int OP_READ       = 0;
    localparam int OP_CB_READ    = 1;
    localparam int OP_PROG       = 2;
    localparam int OP_CB_PROG    = 3;
    localparam int OP_ERASE      = 4;
    localparam int OP_CACHE_PROG = 5;
    localparam int OP_CACHE_READ = 6;
    localparam int OP_STATUS     = 7;
    localparam int OP_READ_ID    = 8;
    localparam int OP_RESET      = 9;
    localparam int OP_DOUT       = 10;

    localparam logic [7:0] C_RD_SET   = 8'h00;
    localparam logic [7:0] C_RD_GO    = 8'h30;
    localparam logic [7:0] C_CBRD_GO  = 8'h35;
    localparam logic [7:0] C_PG_SET   = 8'h80;
    localparam logic [7:0] C_PG2_SET  = 8'h81;
    localparam logic [7:0] C_CB_SET   = 8'h85;
    localparam logic [7:0] C_PG_GO    = 8'h10;
    localparam logic [7:0] C_CPG_GO   = 8'h15;
    localparam logic [7:0] C_PLANE    = 8'h11;
    localparam logic [7:0] C_ER_SET   = 8'h60;
    localparam logic [7:0] C_ER_GO    = 8'hD0;
    localparam logic [7:0] C_DO_SET   = 8'h05;
    localparam logic [7:0] C_DO_GO    = 8'hE0;
    localparam logic [7:0] C_CRD      = 8'h31;
    localparam logic [7:0] C_CRD_LAST = 8'h3F;
    localparam logic [7:0] C_TP_CRD   = 8'h33;
    localparam logic [7:0] C_ID       = 8'h90;
    localparam logic [7:0] C_RST      = 8'hFF;
    localparam logic [7:0] C_STAT     = 8'h70;
    localparam logic [7:0] C_STAT2    = 8'hF1;
endpackage

// File: rtl/nand_bus_capture.sv
// Bus cycle capture: detects a rising latch strobe while chip enable is low
// and registers the bus byte together with its cycle kind.
// Assumes all bus inputs are already synchronous to clk.
module nand_bus_capture
    import nand_dec_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [BUS_W-1:0] io,
    output logic             cyc_valid,
    output cyc_kind_t        cyc_kind,
    output logic [BUS_W-1:0] cyc_data
);
    logic we_q;

    // Delay the strobe by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    // Register the cycle on a rising strobe with the chip enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_valid <= 1'b0;
            cyc_kind  <= CYC_DATA;
            cyc_data  <= '0;
        end else begin
            cyc_valid <= we_n && !we_q && !ce_n;
            cyc_kind  <= cle ? CYC_CMD : (ale ? CYC_ADDR : CYC_DATA);
            cyc_data  <= io;
        end
    end

    assert_single_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid);
    assert_ce_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !cyc_valid);
endmodule

// File: rtl/nand_addr_counter.sv
// Address cycle counter: counts address cycles since the last clear and
// saturates at its maximum. A clear takes priority over an increment.
module nand_addr_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Clear, or add one until the maximum is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)             count <= '0;
        else if (incr && count != CNT_MAX) count <= count + 1'b1;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !incr) |=> $stable(count));
endmodule

// File: rtl/nand_seq_fsm.sv
// Sequence checker: follows setup, address, plane and confirm cycles.
// Emits registered one-cycle operation strobes and error or busy-reject pulses.
// Assumes cycles arrive at most every other clock, as the capture stage gives them.
module nand_seq_fsm
    import nand_dec_pkg::*;
#(
    parameter int COL_CYC = 2,
    parameter int ROW_CYC = 3,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_valid,
    input  cyc_kind_t        cyc_kind,
    input  logic [7:0]       cyc_data,
    input  logic             busy,
    input  logic [CNT_W-1:0] addr_cnt,
    output logic             cnt_clear,
    output logic [OP_N-1:0]  op_strobe,
    output logic             seq_err,
    output logic             busy_reject
);
    localparam logic [CNT_W-1:0] EXP_FULL = CNT_W'(COL_CYC + ROW_CYC);
    localparam logic [CNT_W-1:0] EXP_ROW  = CNT_W'(ROW_CYC);
    localparam logic [CNT_W-1:0] EXP_COL  = CNT_W'(COL_CYC);

    dec_state_t       state, nxt_state;
    logic             cb_q, nxt_cb;
    logic             planes_q, nxt_planes;
    logic             tp_q, nxt_tp;
    logic [CNT_W-1:0] exp_q, nxt_exp;
    logic [OP_N-1:0]  nxt_ops;
    logic             nxt_err, nxt_rej;
    logic             is_cmd, allowed_busy, cnt_ok;
    logic [7:0]       d;

    assign d            = cyc_data;
    assign is_cmd       = cyc_valid && (cyc_kind == CYC_CMD);
    assign allowed_busy = (d == C_RST) || (d == C_STAT) || (d == C_STAT2);
    assign cnt_ok       = (addr_cnt == exp_q);

    // Work out the next state and outputs from the current command cycle.
    always_comb begin
        nxt_state  = state;
        nxt_cb     = cb_q;
        nxt_planes = planes_q;
        nxt_tp     = tp_q;
        nxt_exp    = exp_q;
        nxt_ops    = '0;
        nxt_err    = 1'b0;
        nxt_rej    = 1'b0;
        cnt_clear  = 1'b0;
        if (is_cmd) begin
            if (busy && !allowed_busy) begin
                nxt_rej = 1'b1;
            end else if (d == C_RST) begin
                nxt_ops[OP_RESET] = 1'b1;
                nxt_state = ST_IDLE;
                nxt_tp    = 1'b0;
                cnt_clear = 1'b1;
            end else if (d == C_STAT || d == C_STAT2) begin
                nxt_ops[OP_STATUS] = 1'b1;
            end else begin
                nxt_state = ST_IDLE;
                case (state)
                    ST_IDLE: begin
                        case (d)
                            C_RD_SET: begin nxt_state = ST_RD; cnt_clear = 1'b1; nxt_exp = EXP_FULL; end
                            C_PG_SET, C_CB_SET: begin
                                nxt_state = ST_PG; nxt_cb = (d == C_CB_SET); nxt_tp = 1'b0;
                                cnt_clear = 1'b1; nxt_exp = EXP_FULL;
                            end
                            C_ER_SET: begin
                                nxt_state = ST_ER; nxt_planes = 1'b0; nxt_tp = 1'b0;
                                cnt_clear = 1'b1; nxt_exp = EXP_ROW;
                            end
                            C_DO_SET: begin nxt_state = ST_DO; cnt_clear = 1'b1; nxt_exp = EXP_COL; end
                            C_ID:                nxt_ops[OP_READ_ID]    = 1'b1;
                            C_CRD, C_CRD_LAST:   nxt_ops[OP_CACHE_READ] = 1'b1;
                            default:             nxt_err = 1'b1;
                        endcase
                    end
                    ST_RD: begin
                        if ((d == C_RD_GO || d == C_CBRD_GO) && cnt_ok)
                            nxt_ops[(d == C_RD_GO) ? OP_READ : OP_CB_READ] = 1'b1;
                        else if (d == C_DO_SET && tp_q) begin
                            nxt_state = ST_DO; cnt_clear = 1'b1; nxt_exp = EXP_COL;
                        end else
                            nxt_err = 1'b1;
                    end
                    ST_ER: begin
                        if (d == C_ER_SET) begin
                            nxt_state = ST_ER; nxt_planes = 1'b1; cnt_clear = 1'b1;
                        end else if (d == C_ER_GO && cnt_ok)
                            nxt_ops[OP_ERASE] = 1'b1;
                        else if (planes_q && cnt_ok && (d == C_RD_GO || d == C_CBRD_GO || d == C_TP_CRD)) begin
                            nxt_tp = 1'b1;
                            nxt_ops[(d == C_RD_GO) ? OP_READ :
                                    (d == C_CBRD_GO) ? OP_CB_READ : OP_CACHE_READ] = 1'b1;
                        end else
                            nxt_err = 1'b1;
                    end
                    ST_DO: begin
                        if (d == C_DO_GO && cnt_ok) nxt_ops[OP_DOUT] = 1'b1;
                        else                        nxt_err = 1'b1;
                    end
                    ST_PG: begin
                        if (!cnt_ok)
                            nxt_err = 1'b1;
                        else if (d == C_PG_GO)
                            nxt_ops[cb_q ? OP_CB_PROG : OP_PROG] = 1'b1;
                        else if (d == C_CPG_GO && !cb_q)
                            nxt_ops[OP_CACHE_PROG] = 1'b1;
                        else if (d == C_PLANE)
                            nxt_state = ST_PLANE;
                        else if (d == C_CB_SET) begin
                            nxt_state = ST_PG; cnt_clear = 1'b1; nxt_exp = EXP_COL;
                        end else
                            nxt_err = 1'b1;
                    end
                    ST_PLANE: begin
                        if (d == C_PG_SET || d == C_PG2_SET || d == C_CB_SET) begin
                            nxt_state = ST_PG; nxt_cb = cb_q || (d == C_CB_SET);
                            cnt_clear = 1'b1; nxt_exp = EXP_FULL;
                        end else
                            nxt_err = 1'b1;
                    end
                    default: nxt_err = 1'b1;
                endcase
            end
        end
    end

    // Register state, flags and the one-cycle outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cb_q        <= 1'b0;
            planes_q    <= 1'b0;
            tp_q        <= 1'b0;
            exp_q       <= EXP_FULL;
            op_strobe   <= '0;
            seq_err     <= 1'b0;
            busy_reject <= 1'b0;
        end else begin
            state       <= nxt_state;
            cb_q        <= nxt_cb;
            planes_q    <= nxt_planes;
            tp_q        <= nxt_tp;
            exp_q       <= nxt_exp;
            op_strobe   <= nxt_ops;
            seq_err     <= nxt_err;
            busy_reject <= nxt_rej;
        end
    end

    assert_onehot_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_strobe));
    assert_err_no_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (op_strobe == '0));
    assert_err_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (state == ST_IDLE));
    assert_busy_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && busy && !allowed_busy) |=> (busy_reject && op_strobe == '0 && !seq_err && $stable(state)));
    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && d == C_RST) |=> (op_strobe[OP_RESET] && state == ST_IDLE));
endmodule

// File: rtl/nand_cmd_decoder.sv
// NAND command sequence decoder top: bus capture, address counter and
// sequence checker. COL_CYC and ROW_CYC give the address cycles per phase.
module nand_cmd_decoder
    import nand_dec_pkg::*;
#(
    parameter int COL_CYC = 2,
    parameter int ROW_CYC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            cle,
    input  logic            ale,
    input  logic [7:0]      io,
    input  logic            busy,
    output logic [OP_N-1:0] op_strobe,
    output logic            seq_err,
    output logic            busy_reject
);
    localparam int CNT_W = $clog2(COL_CYC + ROW_CYC + 2);

    logic             cyc_valid;
    cyc_kind_t        cyc_kind;
    logic [7:0]       cyc_data;
    logic             cnt_clear;
    logic [CNT_W-1:0] addr_cnt;

    nand_bus_capture #(.BUS_W(8)) i_capture (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale), .io(io),
        .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_data(cyc_data)
    );

    nand_addr_counter #(.CNT_W(CNT_W)) i_counter (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
        .incr(cyc_valid && cyc_kind == CYC_ADDR), .count(addr_cnt)
    );

    nand_seq_fsm #(.COL_CYC(COL_CYC), .ROW_CYC(ROW_CYC), .CNT_W(CNT_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .cyc_data(cyc_data), .busy(busy), .addr_cnt(addr_cnt), .cnt_clear(cnt_clear),
        .op_strobe(op_strobe), .seq_err(seq_err), .busy_reject(busy_reject)
    );
endmodule

// File: tb/test_nand_cmd_decoder.sv
module test_nand_cmd_decoder;
    localparam int K_DATA = 0, K_ADDR = 1, K_CMD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
    logic [7:0]  io = 8'h00;
    logic [10:0] op_strobe;
    logic        seq_err, busy_reject;
    logic [10:0] acc_ops = '0;
    logic        acc_err = 1'b0, acc_rej = 1'b0;
    int          n_checks = 0, n_fail = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    nand_cmd_decoder i_nand_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io(io), .busy(busy), .op_strobe(op_strobe), .seq_err(seq_err), .busy_reject(busy_reject)
    );

    function automatic logic [10:0] bit_of(input int i);
        return 11'(1) << i;
    endfunction

    task automatic bus(input int kind, input logic [7:0] val, input logic ce = 1'b0);
        @(negedge clk);
        ce_n = ce; cle = (kind == K_CMD); ale = (kind == K_ADDR); io = val; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acc_ops |= op_strobe; acc_err |= seq_err; acc_rej |= busy_reject;
        end
        ce_n = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] v); bus(K_CMD, v); endtask
    task automatic adr(input int n);
        for (int i = 0; i < n; i++) bus(K_ADDR, 8'(i + 1));
    endtask

    task automatic clr();
        acc_ops = '0; acc_err = 1'b0; acc_rej = 1'b0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [10:0] eo, input logic ee, input logic er);
        n_checks++;
        if (acc_ops !== eo || acc_err !== ee || acc_rej !== er) begin
            n_fail++;
            $display("FAIL %s %s: ops=%b err=%b rej=%b expected ops=%b err=%b rej=%b",
                     req, what, acc_ops, acc_err, acc_rej, eo, ee, er);
        end
        clr();
    endtask

    // Expected idle response: {rej, err, ops}
    function automatic logic [12:0] idle_exp(input logic [7:0] v);
        case (v)
            8'hFF: return {2'b00, bit_of(9)};
            8'h90: return {2'b00, bit_of(8)};
            8'h70, 8'hF1: return {2'b00, bit_of(7)};
            8'h31, 8'h3F: return {2'b00, bit_of(6)};
            8'h00, 8'h80, 8'h85, 8'h60, 8'h05: return 13'b0;
            default: return {2'b01, 11'b0};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [12:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ce_n = 1'b0;
        @(negedge clk);
        acc_ops = op_strobe; acc_err = seq_err; acc_rej = busy_reject;
        check("R1", "reset state", '0, 1'b0, 1'b0);

        // R3 R6 R14: every opcode from idle, then FFh to clear
        for (int v = 0; v < 256; v++) begin
            cmd(8'(v));
            e = idle_exp(8'(v));
            check("R3/R6/R14", $sformatf("idle opcode %02h", v), e[10:0], e[11], e[12]);
            cmd(8'hFF); clr();
        end

        // R8: every opcode under busy
        busy = 1'b1;
        for (int v = 0; v < 256; v++) begin
            cmd(8'(v));
            if (v == 8'hFF)                 check("R8", $sformatf("busy %02h", v), bit_of(9), 1'b0, 1'b0);
            else if (v == 8'h70 || v == 8'hF1) check("R8", $sformatf("busy %02h", v), bit_of(7), 1'b0, 1'b0);
            else                            check("R8", $sformatf("busy %02h", v), '0, 1'b0, 1'b1);
        end
        busy = 1'b0;
        cmd(8'h80); adr(5); busy = 1'b1; cmd(8'h10); busy = 1'b0;
        check("R8", "rejected confirm", '0, 1'b0, 1'b1);
        cmd(8'h10);
        check("R8", "state kept after reject", bit_of(2), 1'b0, 1'b0);

        // R4 R7: address count sweep around a read pair
        for (int n = 0; n < 8; n++) begin
            cmd(8'h00); adr(n); cmd(8'h30);
            if (n == 5) check("R4/R7", $sformatf("read with %0d addr", n), bit_of(0), 1'b0, 1'b0);
            else        check("R4/R7", $sformatf("read with %0d addr", n), '0, 1'b1, 1'b0);
        end

        cmd(8'h00); adr(5); cmd(8'h35);
        check("R4", "copy-back read", bit_of(1), 1'b0, 1'b0);
        cmd(8'h80); adr(5); for (int i = 0; i < 4; i++) bus(K_DATA, 8'hA5); cmd(8'h10);
        check("R2", "program with data cycles", bit_of(2), 1'b0, 1'b0);
        cmd(8'h85); adr(5); cmd(8'h10);
        check("R4", "copy-back program", bit_of(3), 1'b0, 1'b0);
        cmd(8'h80); adr(5); cmd(8'h15);
        check("R4", "cache program", bit_of(5), 1'b0, 1'b0);
        cmd(8'h60); adr(3); cmd(8'hD0);
        check("R5", "erase", bit_of(4), 1'b0, 1'b0);
        cmd(8'h60); adr(5); cmd(8'hD0);
        check("R7", "erase wrong count", '0, 1'b1, 1'b0);
        cmd(8'h05); adr(2); cmd(8'hE0);
        check("R5", "data output", bit_of(10), 1'b0, 1'b0);

        // R1: strobes with chip enable high are ignored
        cmd(8'h00); adr(5); bus(K_CMD, 8'h30, 1'b1);
        check("R1", "ce high ignored", '0, 1'b0, 1'b0);
        cmd(8'h30);
        check("R1", "ce low taken", bit_of(0), 1'b0, 1'b0);

        // R9 R10: plane chains
        cmd(8'h80); adr(5); cmd(8'h11); cmd(8'h81); adr(5); cmd(8'h10);
        check("R9", "two-plane program", bit_of(2), 1'b0, 1'b0);
        cmd(8'h80); adr(5); cmd(8'h11); cmd(8'h81); adr(5); cmd(8'h15);
        check("R9", "two-plane cache program", bit_of(5), 1'b0, 1'b0);
        cmd(8'h85); adr(5); cmd(8'h11); cmd(8'h81); adr(5); cmd(8'h10);
        check("R9", "two-plane copy-back", bit_of(3), 1'b0, 1'b0);
        cmd(8'h80); adr(5); cmd(8'h11); cmd(8'h70); cmd(8'h81); adr(5); cmd(8'h10);
        check("R10", "status inside chain", bit_of(7) | bit_of(2), 1'b0, 1'b0);
        cmd(8'h80); adr(5); cmd(8'h11); cmd(8'h30);
        check("R10", "forbidden after plane code", '0, 1'b1, 1'b0);

        // R11: two-plane read then two-plane data output
        cmd(8'h60); adr(3); cmd(8'h60); adr(3); cmd(8'h30);
        check("R11", "two-plane read", bit_of(0), 1'b0, 1'b0);
        cmd(8'h00); adr(5); cmd(8'h05); adr(2); cmd(8'hE0);
        check("R11", "two-plane data output", bit_of(10), 1'b0, 1'b0);
        cmd(8'hFF); clr();
        cmd(8'h00); adr(5); cmd(8'h05);
        check("R11", "data output without two-plane read", '0, 1'b1, 1'b0);

        // R12: reset aborts a sequence
        cmd(8'h80); adr(3); cmd(8'hFF); cmd(8'h10);
        check("R12", "abort then orphan confirm", bit_of(9), 1'b1, 1'b0);

        // R13: random data input inside program
        cmd(8'h80); adr(5); bus(K_DATA, 8'h11); cmd(8'h85); adr(2); bus(K_DATA, 8'h22); cmd(8'h10);
        check("R13", "random data input", bit_of(2), 1'b0, 1'b0);
        cmd(8'h80); adr(5); cmd(8'h85); adr(5); cmd(8'h10);
        check("R13", "random data input wrong count", '0, 1'b1, 1'b0);

        // R14: unexpected command inside a setup
        cmd(8'h00); adr(5); cmd(8'h10);
        check("R14", "program confirm in read setup", '0, 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule